// File: doc/BRIEF.md
# Four-Channel Word DMA Engine

This block moves 32-bit words between memory locations on behalf of software. It has four independent channels, and each channel is set up through a small bank of 32-bit registers. Software loads a source address, a destination address, a byte count and an optional fill word, then starts the channel with its control word. For each word, a channel either copies the word (one read from the source, then one write to the destination) or writes its fill word to the destination without reading at all. The source and the destination can each be made to advance by 4 per word or to stay fixed.

A single memory master port serves all four channels. Before every word, an arbiter picks one pending channel. The arbiter runs as fixed priority or as round robin, and the mode is chosen at run time by a global register. A channel that finishes with its interrupt enabled raises a sticky flag, and the interrupt pin is high while any flag is set.

The memory request side is valid/ready. The engine raises `mem_req_valid` and keeps the request fields constant until it sees `mem_req_ready` high on a clock edge. Read data comes back later on `mem_rsp_valid`, one response for each accepted read, with no back-pressure on the response. Register accesses are plain: a write takes effect on the clock edge where `reg_wr_en` is high, and `reg_rdata` follows `reg_addr` combinationally.

Top module: `mdma_engine`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and `mem_req_valid` is 0.
- R2: The global register is at offset 0x00, and its bit 31 selects the arbitration mode (0 fixed, 1 round robin). Channel c starts at 0x04 + 0x1C*c. Within a channel bank the offsets are: 0x00 working source, 0x04 working destination, 0x08 programmed byte count, 0x0C fill word, 0x10 control, 0x14 working byte count (read-only).
- R3: Writing the source or the destination register of an idle channel loads the working address directly, with bits 1:0 forced to 0. Only channel progress changes the working address after that.
- R4: In copy mode, each word is a read at the working source followed by a write of that data to the working destination. A transfer moves count/4 words, and bits 1:0 of the count are ignored.
- R5: When control bit 13 is set, every destination word receives the fill word and the channel issues no memory reads.
- R6: When control bit 14 is set, the source address stays fixed. When control bit 11 is set, the destination address stays fixed. When a bit is clear, its address advances by 4 after each word.
- R7: Writing control bit 31 = 1 to an idle channel loads the working count and starts the channel. Bit 31 reads 1 until the working count reaches zero. A count of zero completes with no memory access.
- R8: In fixed mode, the lowest-numbered pending channel wins. Arbitration is repeated before every word.
- R9: In round-robin mode, the search for a pending channel starts at the channel after the last one granted.
- R10: A channel that completes with control bit 30 set raises a sticky flag. `irq` is the OR of all flags. Any write to a channel's control register clears that channel's flag.
- R11: An issued request keeps `mem_req_valid`, address, direction and write data unchanged until `mem_req_ready` is seen high.
- R12: A control write to a busy channel changes neither its mode bits nor its busy bit. It only clears the channel's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| irq | output | 1 | OR of channel completion flags |

## Verification
The bench builds the engine with its defaults: four channels and an 8-bit register address. With four channels, round robin can be checked while the search wraps from channel 3 back to channel 0, and fixed priority can be checked while one channel wins several words in a row. The arbitration tests hold the memory port stalled while all channels start. The grant order is then read from the sequence of destination writes, which also covers the channel that was granted before the stall was released.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 5;

  localparam logic [OFF_W-1:0] OFF_SRC  = 5'd0;
  localparam logic [OFF_W-1:0] OFF_DST  = 5'd4;
  localparam logic [OFF_W-1:0] OFF_CNT  = 5'd8;
  localparam logic [OFF_W-1:0] OFF_FILL = 5'd12;
  localparam logic [OFF_W-1:0] OFF_CTRL = 5'd16;
  localparam logic [OFF_W-1:0] OFF_WCNT = 5'd20;

  localparam int BIT_FIX_DST = 11;
  localparam int BIT_FILL    = 13;
  localparam int BIT_FIX_SRC = 14;
  localparam int BIT_IE      = 30;
  localparam int BIT_BUSY    = 31;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} eng_state_t;
endpackage

// File: rtl/mdma_chan.sv
module mdma_chan
  import mdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] wdata,
  input  logic              step,
  output logic [WORD_W-1:0] rdata,
  output logic              pending,
  output logic              fill_mode,
  output logic [WORD_W-1:0] src_addr,
  output logic [WORD_W-1:0] dst_addr,
  output logic [WORD_W-1:0] fill_word,
  output logic              irq_flag
);
  logic [WORD_W-1:0] src_w, dst_w, cnt_cfg, cnt_w, fill_r;
  logic fsrc, fdst, fill, ie, busy, flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_w <= '0; dst_w <= '0; cnt_cfg <= '0; cnt_w <= '0; fill_r <= '0;
      fsrc <= 1'b0; fdst <= 1'b0; fill <= 1'b0; ie <= 1'b0;
      busy <= 1'b0; flag <= 1'b0;
    end else begin
      if (wr_en) begin
        case (off)
          OFF_SRC:  if (!busy) src_w <= {wdata[WORD_W-1:2], 2'b00};
          OFF_DST:  if (!busy) dst_w <= {wdata[WORD_W-1:2], 2'b00};
          OFF_CNT:  cnt_cfg <= wdata;
          OFF_FILL: fill_r <= wdata;
          OFF_CTRL: begin
            flag <= 1'b0;
            if (!busy) begin
              fdst <= wdata[BIT_FIX_DST];
              fill <= wdata[BIT_FILL];
              fsrc <= wdata[BIT_FIX_SRC];
              ie   <= wdata[BIT_IE];
              if (wdata[BIT_BUSY]) begin
                busy  <= 1'b1;
                cnt_w <= {cnt_cfg[WORD_W-1:2], 2'b00};
              end
            end
          end
          default: ;
        endcase
      end
      if (step) begin
        if (!fsrc) src_w <= src_w + 32'd4;
        if (!fdst) dst_w <= dst_w + 32'd4;
        cnt_w <= cnt_w - 32'd4;
      end
      if (busy && cnt_w == '0) begin
        busy <= 1'b0;
        if (ie) flag <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_SRC:  rdata = src_w;
      OFF_DST:  rdata = dst_w;
      OFF_CNT:  rdata = cnt_cfg;
      OFF_FILL: rdata = fill_r;
      OFF_WCNT: rdata = cnt_w;
      OFF_CTRL: begin
        rdata[BIT_BUSY]    = busy;
        rdata[BIT_IE]      = ie;
        rdata[BIT_FIX_SRC] = fsrc;
        rdata[BIT_FILL]    = fill;
        rdata[BIT_FIX_DST] = fdst;
      end
      default: rdata = '0;
    endcase
  end

  assign pending   = busy && (cnt_w != '0);
  assign fill_mode = fill;
  assign src_addr  = src_w;
  assign dst_addr  = dst_w;
  assign fill_word = fill_r;
  assign irq_flag  = flag;

  // R4
  step_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (busy && cnt_w != '0));
  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt_w) == '0));
  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($fell(busy) && $past(ie)));
  // R12
  busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable({fsrc, fill, fdst, ie}));
endmodule

// File: rtl/mdma_arb.sv
module mdma_arb #(
  parameter int NCH = 4,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req,
  input  logic             rr_mode,
  input  logic             take,
  output logic             gnt_any,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] last;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    if (!rr_mode) begin
      for (int i = NCH - 1; i >= 0; i--) begin
        if (req[i]) begin
          gnt_any = 1'b1;
          gnt_idx = IDX_W'(i);
        end
      end
    end else begin
      for (int k = NCH; k >= 1; k--) begin
        if (req[(int'(last) + k) % NCH]) begin
          gnt_any = 1'b1;
          gnt_idx = IDX_W'((int'(last) + k) % NCH);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last <= IDX_W'(NCH - 1);
    else if (take && gnt_any) last <= gnt_idx;
  end

  // R8
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |-> req[gnt_idx]);
  // R8
  fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && !rr_mode) |-> ((req & ((NCH'(1) << gnt_idx) - NCH'(1))) == '0));
  // R9
  rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rr_mode && $countones(req) > 1) |-> (gnt_idx != last));
endmodule

// File: rtl/mdma_engine.sv
module mdma_engine
  import mdma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8,
  localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BASE0  = 4,
  localparam int STRIDE = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              irq
);
  logic              rr_mode;
  logic [NCH-1:0]    ch_sel, pend, fill_v, flags, step;
  logic [OFF_W-1:0]  ch_off  [NCH];
  logic [WORD_W-1:0] ch_rd   [NCH];
  logic [WORD_W-1:0] src_a   [NCH];
  logic [WORD_W-1:0] dst_a   [NCH];
  logic [WORD_W-1:0] fill_w  [NCH];

  eng_state_t        state;
  logic [IDX_W-1:0]  cur;
  logic [WORD_W-1:0] data_q;
  logic              gnt_any, take;
  logic [IDX_W-1:0]  gnt_idx;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] B = ADDR_W'(BASE0 + c * STRIDE);
    assign ch_sel[c] = (reg_addr >= B) && (reg_addr < B + ADDR_W'(STRIDE));
    assign ch_off[c] = OFF_W'(reg_addr - B);

    mdma_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en && ch_sel[c]),
      .off       (ch_off[c]),
      .wdata     (reg_wdata),
      .step      (step[c]),
      .rdata     (ch_rd[c]),
      .pending   (pend[c]),
      .fill_mode (fill_v[c]),
      .src_addr  (src_a[c]),
      .dst_addr  (dst_a[c]),
      .fill_word (fill_w[c]),
      .irq_flag  (flags[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_mode <= 1'b0;
    else if (reg_wr_en && reg_addr == '0) rr_mode <= reg_wdata[31];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata[31] = rr_mode;
    for (int c = 0; c < NCH; c++) begin
      if (ch_sel[c]) reg_rdata = ch_rd[c];
    end
  end

  assign take = (state == S_IDLE);

  mdma_arb #(.NCH(NCH)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pend),
    .rr_mode (rr_mode),
    .take    (take),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (gnt_any) begin
          cur   <= gnt_idx;
          state <= fill_v[gnt_idx] ? S_WR : S_RD;
        end
        S_RD:    if (mem_req_ready) state <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin
          data_q <= mem_rsp_data;
          state  <= S_WR;
        end
        S_WR:    if (mem_req_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (state == S_RD) || (state == S_WR);
    mem_req_write = (state == S_WR);
    mem_req_addr  = (state == S_WR) ? dst_a[cur] : src_a[cur];
    mem_req_wdata = fill_v[cur] ? fill_w[cur] : data_q;
    step          = (state == S_WR && mem_req_ready) ? (NCH'(1) << cur) : '0;
  end

  assign irq = |flags;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
  // R5
  fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> !fill_v[cur]);
endmodule

// File: tb/mdma_engine_bench.sv
module mdma_engine_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic        hold_ready = 1'b0;
  logic        bp_on = 1'b0;
  logic        tog;
  logic [31:0] mem [0:255];
  int          n_rd, n_wr, log_n;
  int          log_a [0:63];

  always #(CLK_P/2) clk = ~clk;

  assign mem_req_ready = !hold_ready && (!bp_on || tog);

  mdma_engine u_mdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 + i;
      mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      n_rd <= 0; n_wr <= 0; log_n <= 0; tog <= 1'b0;
    end else begin
      tog <= ~tog;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[9:2]] <= mem_req_wdata;
          n_wr <= n_wr + 1;
          if (log_n < 64) begin
            log_a[log_n] <= int'(mem_req_addr);
            log_n <= log_n + 1;
          end
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr[9:2]];
          n_rd <= n_rd + 1;
        end
      end
    end
  end

  function automatic logic [7:0] cb(int c, int off);
    return 8'(4 + c * 28 + off);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(int c);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      reg_rd(cb(c, 16), v);
      if (!v[31]) return;
    end
    check("R7 idle timeout", v, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(8'h00, v);     check("R1 global", v, 0);
    reg_rd(cb(0, 16), v); check("R1 ctrl0", v, 0);
    reg_rd(cb(3, 0), v);  check("R1 src3", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 valid", {31'b0, mem_req_valid}, 0);
  endtask

  task automatic t_copy();
    logic [31:0] v;
    bp_on = 1'b1;
    reg_wr(cb(0, 0), 32'h13);
    reg_rd(cb(0, 0), v); check("R3 src aligned", v, 32'h10);
    reg_wr(cb(0, 4), 32'h200);
    reg_wr(cb(0, 8), 32'd12);
    reg_rd(cb(0, 8), v); check("R2 count reg", v, 32'd12);
    reg_wr(cb(0, 16), 32'hC000_0000);
    wait_idle(0);
    for (int i = 0; i < 3; i++) check("R4 copy word", mem[128 + i], 32'hA500_0004 + i);
    check("R4 no overrun", mem[131], 32'hA500_0083);
    reg_rd(cb(0, 0), v);  check("R3 src advanced", v, 32'h1C);
    reg_rd(cb(0, 4), v);  check("R3 dst advanced", v, 32'h20C);
    reg_rd(cb(0, 20), v); check("R7 work count zero", v, 0);
    check("R10 irq set", {31'b0, irq}, 1);
    reg_wr(cb(0, 16), 32'h0);
    check("R10 irq cleared", {31'b0, irq}, 0);
    bp_on = 1'b0;
  endtask

  task automatic t_fill();
    int rd0;
    rd0 = n_rd;
    reg_wr(cb(1, 4), 32'h240);
    reg_wr(cb(1, 8), 32'd16);
    reg_wr(cb(1, 12), 32'hDEAD_BEEF);
    reg_wr(cb(1, 16), 32'h8000_2000);
    wait_idle(1);
    for (int i = 0; i < 4; i++) check("R5 fill word", mem[144 + i], 32'hDEAD_BEEF);
    check("R5 no reads", 32'(n_rd - rd0), 0);
    check("R10 no irq without enable", {31'b0, irq}, 0);
  endtask

  task automatic t_fixed();
    logic [31:0] v;
    reg_wr(cb(2, 0), 32'h40);
    reg_wr(cb(2, 4), 32'h280);
    reg_wr(cb(2, 8), 32'h0E);
    reg_wr(cb(2, 16), 32'h8000_4000);
    wait_idle(2);
    for (int i = 0; i < 3; i++) check("R6 fixed src", mem[160 + i], 32'hA500_0010);
    check("R4 count low bits ignored", mem[163], 32'hA500_00A3);
    reg_rd(cb(2, 0), v); check("R6 src held", v, 32'h40);
    reg_rd(cb(2, 4), v); check("R6 dst moved", v, 32'h28C);
    reg_wr(cb(2, 0), 32'h80);
    reg_wr(cb(2, 4), 32'h2C0);
    reg_wr(cb(2, 8), 32'd8);
    reg_wr(cb(2, 16), 32'h8000_0800);
    wait_idle(2);
    check("R6 fixed dst last word", mem[176], 32'hA500_0021);
    check("R6 fixed dst next untouched", mem[177], 32'hA500_00B1);
    reg_rd(cb(2, 4), v); check("R6 dst held", v, 32'h2C0);
    reg_rd(cb(2, 0), v); check("R6 src moved", v, 32'h88);
  endtask

  task automatic t_zero();
    int r0, w0;
    r0 = n_rd; w0 = n_wr;
    reg_wr(cb(3, 8), 32'h0);
    reg_wr(cb(3, 16), 32'hC000_0000);
    wait_idle(3);
    check("R7 zero count no access", 32'((n_rd - r0) + (n_wr - w0)), 0);
    check("R10 zero count irq", {31'b0, irq}, 1);
    reg_wr(cb(3, 16), 32'h0);
    check("R10 flag cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_arb(logic rr);
    int l0;
    int exp_f [8] = '{3, 0, 0, 1, 1, 2, 2, 3};
    int exp_r [8] = '{3, 0, 1, 2, 3, 0, 1, 2};
    reg_wr(8'h00, {rr, 31'b0});
    hold_ready = 1'b1;
    for (int c = 0; c < 4; c++) begin
      reg_wr(cb(c, 0), 32'(c * 16));
      reg_wr(cb(c, 4), 32'(32'h300 + c * 32'h20));
      reg_wr(cb(c, 8), 32'd8);
    end
    for (int c = 3; c >= 0; c--) reg_wr(cb(c, 16), 32'h8000_0000);
    l0 = log_n;
    hold_ready = 1'b0;
    for (int c = 0; c < 4; c++) wait_idle(c);
    for (int i = 0; i < 8; i++)
      check(rr ? "R9 round robin order" : "R8 fixed order",
            32'((log_a[l0 + i] - 32'h300) >> 5), 32'(rr ? exp_r[i] : exp_f[i]));
  endtask

  task automatic t_busy();
    logic [31:0] v;
    reg_wr(8'h00, 32'h0);
    hold_ready = 1'b1;
    reg_wr(cb(0, 0), 32'h0);
    reg_wr(cb(0, 4), 32'h380);
    reg_wr(cb(0, 8), 32'd8);
    reg_wr(cb(0, 16), 32'h8000_0000);
    reg_rd(cb(0, 16), v); check("R7 busy reads one", v, 32'h8000_0000);
    check("R11 valid held", {31'b0, mem_req_valid}, 1);
    check("R11 addr held", mem_req_addr, 32'h0);
    reg_wr(cb(0, 16), 32'h0000_2000);
    reg_rd(cb(0, 16), v); check("R12 ctrl unchanged while busy", v, 32'h8000_0000);
    hold_ready = 1'b0;
    wait_idle(0);
    check("R12 still copy w0", mem[224], 32'hA500_0000);
    check("R12 still copy w1", mem[225], 32'hA500_0001);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_copy();
    t_fill();
    t_fixed();
    t_zero();
    t_arb(1'b0);
    t_arb(1'b1);
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule